// File: doc/BRIEF.md
# Complementary Dead-Time Generator

This block drives a complementary pair of power switches from a single PWM command. It has two gate-command outputs: a main output and an auxiliary output. When the command rises, the auxiliary switch turns off at once and the main switch turns on after a programmable number of clock cycles. When the command falls, the main switch turns off at once and the auxiliary switch turns on after a second, independent delay. The gap between the two switches gives soft-switching transitions time to settle. Neither switch ever conducts while the other is on.

Each delay can be cut short by a zero-voltage sense strobe: the waiting output then switches at the next clock edge. When the drive-enable input is low, the block is asleep. The main output is held low and the auxiliary output enable is dropped so that the pin can float. A mode input selects how the auxiliary output is driven: active high, for a true complement of the main output, or active low, for a p-channel device. The PWM command may be asynchronous and passes through a synchronizer. Delays are counted in clock cycles; at 50 MHz, the 50 ns to 500 ns range is 3 to 25 cycles.

Top module: `comp_deadtime_gen`

## Requirements
- R1: After reset, with drv_enable high and pwm_in low, main_gate is 0, aux_gate_oe is 1 and the auxiliary switch is active (aux_gate=1 when aux_pchan_mode=0).
- R2: A level change of pwm_in sampled at clock edge k is acted on at edge k+2. On a rising change the auxiliary switch turns inactive at that edge.
- R3: After a rising change acted on at edge k, main_gate turns on at edge k+N, where N=pwr_dly_cyc (N greater than or equal to 1) is latched at edge k.
- R4: After a falling change acted on at edge k, main_gate turns off at edge k and the auxiliary switch turns active at edge k+M, where M=aux_dly_cyc is latched at edge k.
- R5: A delay value of 0 makes the delayed output switch at the same edge k at which the edge is acted on.
- R6: While the main turn-on delay is running, pwr_zv_sense high at an edge ends the delay, and main_gate turns on at that edge.
- R7: While the auxiliary turn-on delay is running, aux_zv_sense high at an edge ends the delay, and the auxiliary switch turns active at that edge.
- R8: A sense strobe raised while its delay is idle has no effect on either output.
- R9: A falling change acted on while the main turn-on delay is running cancels it: main_gate stays 0 and the auxiliary delay starts.
- R10: A rising change acted on while the auxiliary delay is running cancels it: the auxiliary switch stays inactive and the main turn-on delay starts.
- R11: While drv_enable is 0, main_gate is 0 and aux_gate_oe is 0 in the same cycle, and all pending delays are dropped.
- R12: On leaving sleep, main_gate stays 0 until a fresh rising change plus its delay. The auxiliary switch is active if and only if the synchronized pwm_in is low.
- R13: With aux_pchan_mode=1, aux_gate is 0 when the auxiliary switch is active and 1 otherwise. With aux_pchan_mode=0, aux_gate is 1 when active.
- R14: The main switch and the auxiliary switch are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, may be asynchronous |
| drv_enable | input | 1 | High to run, low for sleep |
| aux_pchan_mode | input | 1 | 1: active-low auxiliary output; 0: active-high |
| pwr_dly_cyc | input | CNT_W | Main turn-on delay in cycles |
| aux_dly_cyc | input | CNT_W | Auxiliary turn-on delay in cycles |
| pwr_zv_sense | input | 1 | Zero-voltage strobe that ends the main delay |
| aux_zv_sense | input | 1 | Zero-voltage strobe that ends the auxiliary delay |
| main_gate | output | 1 | Main switch gate command, active high |
| aux_gate | output | 1 | Auxiliary switch gate command |
| aux_gate_oe | output | 1 | Output enable for the auxiliary pin |

## Verification
The assertions assume that drv_enable, aux_pchan_mode and both sense strobes are synchronous to clk. Only pwm_in may change freely, since it is resynchronized. The bench therefore changes all inputs half a cycle away from the active edge. It mixes random PWM hold times, delays of 0 to 25 cycles, sparse strobes and short sleep bursts with directed cancellation and wake-up cases.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   localparam int DEF_CNT_W       = 8;
   localparam int DEF_SYNC_STAGES = 2;
   localparam int NUM_CH          = 2;

   typedef enum logic {
      CH_MAIN_ON = 1'b0,
      CH_AUX_ON  = 1'b1
   } dly_chan_e;
endpackage

// File: rtl/cdt_sync.sv
module cdt_sync #(
   parameter int STAGES = cdt_pkg::DEF_SYNC_STAGES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   initial begin
      if (STAGES < 2) $error("cdt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/cdt_delay.sv
module cdt_delay #(
   parameter int CNT_W = cdt_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cancel,
   input  logic [CNT_W-1:0] load_val,
   input  logic             zv_sense,
   output logic             fire
);
   initial begin
      if (CNT_W < 1) $error("cdt_delay: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             expire;

   assign expire = run_q && (zv_sense || (cnt_q == CNT_W'(1)));
   assign fire   = !cancel && ((start && (load_val == '0)) || (!start && expire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (cancel) begin
         run_q <= 1'b0;
      end else if (start) begin
         run_q <= (load_val != '0);
         cnt_q <= load_val;
      end else if (run_q) begin
         if (expire) run_q <= 1'b0;
         else        cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q != '0)); // R3

   AST_ZV_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && zv_sense && !cancel && !start) |=> !run_q); // R6
endmodule

// File: rtl/comp_deadtime_gen.sv
module comp_deadtime_gen #(
   parameter int CNT_W       = cdt_pkg::DEF_CNT_W,
   parameter int SYNC_STAGES = cdt_pkg::DEF_SYNC_STAGES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_in,
   input  logic             drv_enable,
   input  logic             aux_pchan_mode,
   input  logic [CNT_W-1:0] pwr_dly_cyc,
   input  logic [CNT_W-1:0] aux_dly_cyc,
   input  logic             pwr_zv_sense,
   input  logic             aux_zv_sense,
   output logic             main_gate,
   output logic             aux_gate,
   output logic             aux_gate_oe
);
   import cdt_pkg::*;

   initial begin
      if (CNT_W < 1 || CNT_W > 32) $error("comp_deadtime_gen: CNT_W out of range");
   end

   logic pwm_s, pwm_prev_q;
   logic rise_w, fall_w;
   logic pwr_q, aux_on_q;

   cdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(pwm_in), .q_out(pwm_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_prev_q <= 1'b0;
      else        pwm_prev_q <= pwm_s;
   end

   assign rise_w = pwm_s && !pwm_prev_q;
   assign fall_w = !pwm_s && pwm_prev_q;

   logic             ch_start  [NUM_CH];
   logic             ch_cancel [NUM_CH];
   logic [CNT_W-1:0] ch_load   [NUM_CH];
   logic             ch_zv     [NUM_CH];
   logic             ch_fire   [NUM_CH];

   always_comb begin
      ch_start[CH_MAIN_ON]  = drv_enable && rise_w;
      ch_cancel[CH_MAIN_ON] = !drv_enable || fall_w;
      ch_load[CH_MAIN_ON]   = pwr_dly_cyc;
      ch_zv[CH_MAIN_ON]     = pwr_zv_sense;
      ch_start[CH_AUX_ON]   = drv_enable && fall_w;
      ch_cancel[CH_AUX_ON]  = !drv_enable || rise_w;
      ch_load[CH_AUX_ON]    = aux_dly_cyc;
      ch_zv[CH_AUX_ON]      = aux_zv_sense;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      cdt_delay #(.CNT_W(CNT_W)) u_dly (
         .clk(clk), .rst_n(rst_n),
         .start(ch_start[c]), .cancel(ch_cancel[c]),
         .load_val(ch_load[c]), .zv_sense(ch_zv[c]),
         .fire(ch_fire[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q    <= 1'b0;
         aux_on_q <= 1'b1;
      end else if (!drv_enable) begin
         pwr_q    <= 1'b0;
         aux_on_q <= !pwm_s;
      end else begin
         if (fall_w)                   pwr_q <= 1'b0;
         else if (ch_fire[CH_MAIN_ON]) pwr_q <= 1'b1;
         if (rise_w)                   aux_on_q <= 1'b0;
         else if (ch_fire[CH_AUX_ON])  aux_on_q <= 1'b1;
      end
   end

   assign main_gate   = pwr_q && drv_enable;
   assign aux_gate    = aux_pchan_mode ? !aux_on_q : aux_on_q;
   assign aux_gate_oe = drv_enable;

   AST_RISE_AUX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_enable && rise_w) |=> !aux_on_q); // R2

   AST_FALL_PWR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_enable && fall_w) |=> !pwr_q); // R4

   AST_PWR_ON_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_q) |-> $past(ch_fire[CH_MAIN_ON] && drv_enable)); // R3

   AST_SLEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_enable |=> !pwr_q); // R11

   AST_BREAK_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_q && aux_on_q)); // R14
endmodule

// File: tb/comp_deadtime_gen_tb_top.sv
module comp_deadtime_gen_tb_top;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_in = 1'b0, drv_enable = 1'b1, aux_pchan_mode = 1'b0;
   logic [CW-1:0] pwr_dly_cyc = 8'd5, aux_dly_cyc = 8'd4;
   logic pwr_zv_sense = 1'b0, aux_zv_sense = 1'b0;
   logic main_gate, aux_gate, aux_gate_oe;

   int checks = 0, failures = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   comp_deadtime_gen #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .drv_enable(drv_enable),
      .aux_pchan_mode(aux_pchan_mode), .pwr_dly_cyc(pwr_dly_cyc),
      .aux_dly_cyc(aux_dly_cyc), .pwr_zv_sense(pwr_zv_sense),
      .aux_zv_sense(aux_zv_sense), .main_gate(main_gate),
      .aux_gate(aux_gate), .aux_gate_oe(aux_gate_oe)
   );

   // Reference model built from the requirement list
   bit m_s1, m_s2, m_sd, m_pwr, m_aux;
   int m_c1, m_c2;
   always @(posedge clk) begin
      bit rs, fl, d1, d2;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_sd = 0; m_pwr = 0; m_aux = 1; m_c1 = 0; m_c2 = 0;
      end else begin
         rs = m_s2 && !m_sd;
         fl = !m_s2 && m_sd;
         if (!drv_enable) begin
            m_pwr = 0; m_aux = !m_s2; m_c1 = 0; m_c2 = 0;
         end else begin
            d1 = (m_c1 != 0) && (pwr_zv_sense || m_c1 == 1);
            d2 = (m_c2 != 0) && (aux_zv_sense || m_c2 == 1);
            if (rs) begin
               m_aux = 0; m_c2 = 0;
               if (pwr_dly_cyc == 0) m_pwr = 1; else m_c1 = pwr_dly_cyc;
            end else if (fl) begin
               m_pwr = 0; m_c1 = 0;
               if (aux_dly_cyc == 0) m_aux = 1; else m_c2 = aux_dly_cyc;
            end else begin
               if (d1) begin m_pwr = 1; m_c1 = 0; end else if (m_c1 != 0) m_c1--;
               if (d2) begin m_aux = 1; m_c2 = 0; end else if (m_c2 != 0) m_c2--;
            end
         end
         m_sd = m_s2; m_s2 = m_s1; m_s1 = pwm_in;
      end
   end

   function automatic bit exp_aux_pin(bit active, bit pch);
      return pch ? !active : active;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      bit hold_pwm;
      int hold;
      void'($urandom(32'h5EED_0714));
      step(4);
      rst_n = 1'b1;
      step(2);
      // R1 reset state
      chk("R1 main_gate", main_gate, 0);
      chk("R1 aux_gate", aux_gate, 1);
      chk("R1 aux_gate_oe", aux_gate_oe, 1);

      // R2 / R3 rising edge, delay 5
      pwm_in = 1;
      step(2); chk("R2 aux before sync", aux_gate, 1);
      step(1); chk("R2 aux off", aux_gate, 0); chk("R3 main held", main_gate, 0);
      step(4); chk("R3 main before delay", main_gate, 0);
      step(1); chk("R3 main on", main_gate, 1);
      // R8 strobes while idle
      pwr_zv_sense = 1; aux_zv_sense = 1;
      step(2); chk("R8 main kept", main_gate, 1); chk("R8 aux kept", aux_gate, 0);
      pwr_zv_sense = 0; aux_zv_sense = 0;

      // R4 falling edge, delay 4
      pwm_in = 0;
      step(3); chk("R4 main off", main_gate, 0); chk("R4 aux waits", aux_gate, 0);
      step(3); chk("R4 aux before delay", aux_gate, 0);
      step(1); chk("R4 aux on", aux_gate, 1);

      // R5 zero delays
      pwr_dly_cyc = 0; pwm_in = 1;
      step(2); chk("R5 main not yet", main_gate, 0);
      step(1); chk("R5 aux off", aux_gate, 0); chk("R5 main same edge", main_gate, 1);
      aux_dly_cyc = 0; pwm_in = 0;
      step(3); chk("R5 main off", main_gate, 0); chk("R5 aux same edge", aux_gate, 1);

      // R6 strobe ends main delay
      pwr_dly_cyc = 20; pwm_in = 1;
      step(6); chk("R6 main waiting", main_gate, 0);
      pwr_zv_sense = 1;
      step(1); chk("R6 main on by strobe", main_gate, 1);
      pwr_zv_sense = 0;

      // R7 strobe ends aux delay
      aux_dly_cyc = 20; pwm_in = 0;
      step(3); chk("R7 main off", main_gate, 0); chk("R7 aux waiting", aux_gate, 0);
      step(2);
      aux_zv_sense = 1;
      step(1); chk("R7 aux on by strobe", aux_gate, 1);
      aux_zv_sense = 0;

      // R9 fall during main delay
      pwr_dly_cyc = 10; aux_dly_cyc = 4; pwm_in = 1;
      step(5); pwm_in = 0;
      for (int k = 1; k <= 6; k++) begin
         step(1); chk("R9 aux pending", aux_gate, 0); chk("R9 main low", main_gate, 0);
      end
      step(1); chk("R9 aux on", aux_gate, 1);
      for (int k = 0; k < 10; k++) begin
         step(1); chk("R9 main cancelled", main_gate, 0);
      end

      // R10 rise during aux delay
      pwr_dly_cyc = 3; aux_dly_cyc = 10; pwm_in = 1;
      step(6); chk("R10 main on", main_gate, 1);
      pwm_in = 0;
      step(3); chk("R10 main off", main_gate, 0);
      step(2); pwm_in = 1;
      for (int k = 1; k <= 14; k++) begin
         step(1); chk("R10 aux cancelled", aux_gate, 0);
         chk("R10 main restart", main_gate, (k >= 6) ? 1 : 0);
      end

      // R13 p-channel mode
      aux_pchan_mode = 1;
      step(1); chk("R13 inactive high", aux_gate, 1);
      aux_dly_cyc = 2; pwm_in = 0;
      step(5); chk("R13 active low", aux_gate, 0);
      aux_pchan_mode = 0;
      step(1); chk("R13 active high", aux_gate, 1);

      // R11 sleep
      pwm_in = 1;
      step(6); chk("R11 main on before sleep", main_gate, 1);
      drv_enable = 0;
      #1; chk("R11 main forced low", main_gate, 0); chk("R11 oe off", aux_gate_oe, 0);
      step(3); chk("R11 main stays low", main_gate, 0);

      // R12 wake with input high
      drv_enable = 1;
      step(1); chk("R12 main low", main_gate, 0); chk("R12 oe on", aux_gate_oe, 1);
      chk("R12 aux inactive", aux_gate, 0);
      step(10); chk("R12 no fresh edge", main_gate, 0);
      pwm_in = 0;
      step(5); chk("R12 aux on", aux_gate, 1);
      pwm_in = 1;
      step(6); chk("R12 main after fresh edge", main_gate, 1);

      // Random phase against model (R3 R4 R6 R7 R11 R12 R13 R14)
      hold = 0;
      for (int i = 0; i < 20000; i++) begin
         step(1);
         chk("R3/R4 rnd main", main_gate, m_pwr && drv_enable);
         chk("R13 rnd aux", aux_gate, exp_aux_pin(m_aux, aux_pchan_mode));
         chk("R11 rnd oe", aux_gate_oe, drv_enable);
         chk("R14 rnd overlap", int'(main_gate && m_aux), 0);
         if (hold == 0) begin
            hold_pwm = !pwm_in;
            pwm_in = hold_pwm;
            hold = 1 + ($urandom % 40);
         end else hold--;
         if ($urandom % 50 == 0) pwr_dly_cyc = CW'($urandom % 26);
         if ($urandom % 50 == 0) aux_dly_cyc = CW'($urandom % 26);
         pwr_zv_sense = ($urandom % 20 == 0);
         aux_zv_sense = ($urandom % 20 == 0);
         if (drv_enable) drv_enable = ($urandom % 300 != 0);
         else            drv_enable = ($urandom % 4 == 0);
         if ($urandom % 500 == 0) aux_pchan_mode = !aux_pchan_mode;
      end
      finish_run();
   end
endmodule